// File: doc/BRIEF.md
# Reciprocal Square Root Seed Unit

This unit returns a coarse starting value for 1/sqrt(x) when x is an IEEE-754 single-precision number. A later iteration stage refines the value. The unit decodes the operand class first. For a positive normal operand, it builds the result from three pieces: a computed exponent, an 8-bit significand taken from a fixed 128-entry table, and zeros in the remaining low bits. Operands that are NaN, zero, denormal, negative or infinite each return a fixed encoding.

The unit registers one operation per cycle. The result appears one cycle after `in_valid`, and it stays unchanged while no new operation arrives. Two flags are produced. The invalid flag reports a signalling NaN operand or a negative nonzero operand, and it stays set until reset. The summary flag gives the same report for the most recent operation only.

Top module: `rsqrt_seed`

## Requirements
- R1: While reset is asserted and after it is released, before any operation, `out_valid`, `out_seed`, `out_invalid` and `out_summary` are all zero.
- R2: An operand with exponent field 8'hFF and a nonzero fraction (either NaN kind, either sign) gives the result 32'h7FC0_0000.
- R3: An operand with exponent field zero (zero or denormal) gives infinity with the operand's sign: 32'h7F80_0000 for sign 0, 32'hFF80_0000 for sign 1.
- R4: An operand with sign 1 that is not NaN, zero or denormal gives 32'h7FC0_0004. This includes negative infinity and negative normals.
- R5: Positive infinity (32'h7F80_0000) gives 32'h0000_0000.
- R6: A positive normal operand with biased exponent E gives a result with sign 0, exponent field (bits 30:23) equal to 8'hBD minus ((E-1) shifted right by one), and bits 14:0 equal to zero.
- R7: For a positive normal operand, result bits 22:15 hold table[i], where i = {(E-1) bit 0, operand bits 22:17}. Operand bits 16:0 have no effect on the result. The table falls strictly from 253 at i=0 to 2 at i=127, and each even entry exceeds the following odd entry by exactly 1.
- R8: A signalling NaN operand (exponent 8'hFF, fraction nonzero, bit 22 clear) and any operand covered by R4 set both `out_invalid` and `out_summary` with the result. A quiet NaN, a zero or denormal of either sign, and positive operands leave both flags alone.
- R9: `out_summary` is rewritten on every operation: it is 1 for an R8 operand and 0 otherwise. `out_invalid` stays at 1 after being set, across later clean operations, until reset.
- R10: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_seed` and both flags keep their values, whatever `in_operand` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe, one operation per high cycle |
| in_operand | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result registered in the previous cycle |
| out_seed | output | 32 | Approximate reciprocal square root |
| out_invalid | output | 1 | Invalid-operation flag, held until reset |
| out_summary | output | 1 | Invalid report for the latest operation |

## Verification
The bound checker checks the following on every cycle:
- each special operand class maps to its fixed encoding;
- a positive normal result has a clear sign and clear low bits;
- both flags rise after an invalid operand, and the summary flag never stands without the invalid flag;
- the invalid flag is sticky;
- the result holds between strobes.

The table contents and the exponent arithmetic can only be shown by the bench. It sweeps every biased exponent against every 6-bit significand prefix, with noise in the ignored low bits. From the observed outputs it rebuilds the whole table and checks its shape. Flag sequences also depend on order and are shown only by the bench: a clean operation after an invalid one, and a reset that clears the sticky flag.

// File: rtl/rsqrt_seed_pkg.sv
`timescale 1ns/1ps
package rsqrt_seed_pkg;

   typedef enum logic [2:0] {
      OPC_NORM_POS = 3'd0,
      OPC_ANY_NAN  = 3'd1,
      OPC_TINY     = 3'd2,
      OPC_NEGATIVE = 3'd3,
      OPC_POS_INF  = 3'd4
   } opnd_class_e;

   localparam int SEED_IDX_W = 7;
   localparam int SEED_VAL_W = 8;

   // Upper member of each adjacent entry pair; the lower member is one less.
   localparam logic [7:0] PAIR_HEAD [64] = '{
      8'd253, 8'd245, 8'd239, 8'd231, 8'd225, 8'd217, 8'd211, 8'd205,
      8'd201, 8'd195, 8'd189, 8'd185, 8'd179, 8'd175, 8'd169, 8'd165,
      8'd161, 8'd157, 8'd153, 8'd149, 8'd145, 8'd141, 8'd137, 8'd133,
      8'd131, 8'd127, 8'd123, 8'd121, 8'd117, 8'd115, 8'd111, 8'd109,
      8'd103, 8'd99,  8'd93,  8'd89,  8'd83,  8'd79,  8'd75,  8'd71,
      8'd67,  8'd63,  8'd59,  8'd55,  8'd53,  8'd49,  8'd45,  8'd43,
      8'd39,  8'd37,  8'd33,  8'd31,  8'd27,  8'd25,  8'd23,  8'd19,
      8'd17,  8'd15,  8'd13,  8'd11,  8'd9,   8'd7,   8'd5,   8'd3
   };

   function automatic logic [SEED_VAL_W-1:0] seed_lookup(input logic [SEED_IDX_W-1:0] idx);
      seed_lookup = PAIR_HEAD[idx[SEED_IDX_W-1:1]] - {{(SEED_VAL_W-1){1'b0}}, idx[0]};
   endfunction

endpackage

// File: rtl/rsqrt_seed_classify.sv
`timescale 1ns/1ps
module rsqrt_seed_classify
   import rsqrt_seed_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] opnd,
   output opnd_class_e       opnd_class,
   output logic              flag_invalid
);
   logic              sgn;
   logic [EXP_W-1:0]  bexp;
   logic [FRAC_W-1:0] frac;
   logic              exp_all_one, exp_all_zero, frac_nonzero, is_nan, is_snan;

   assign sgn  = opnd[WORD_W-1];
   assign bexp = opnd[WORD_W-2 -: EXP_W];
   assign frac = opnd[FRAC_W-1:0];

   assign exp_all_one  = &bexp;
   assign exp_all_zero = ~|bexp;
   assign frac_nonzero = |frac;
   assign is_nan       = exp_all_one & frac_nonzero;
   assign is_snan      = is_nan & ~frac[FRAC_W-1];

   always_comb begin
      if (is_nan)            opnd_class = OPC_ANY_NAN;
      else if (exp_all_zero) opnd_class = OPC_TINY;
      else if (sgn)          opnd_class = OPC_NEGATIVE;
      else if (exp_all_one)  opnd_class = OPC_POS_INF;
      else                   opnd_class = OPC_NORM_POS;
   end

   assign flag_invalid = is_snan | (opnd_class == OPC_NEGATIVE);
endmodule

// File: rtl/rsqrt_seed_expgen.sv
`timescale 1ns/1ps
module rsqrt_seed_expgen #(
   parameter int               EXP_W    = 8,
   parameter logic [EXP_W-1:0] EXP_BASE = 8'hBD
) (
   input  logic [EXP_W-1:0] biased_exp,
   output logic [EXP_W-1:0] seed_exp,
   output logic             dec_parity
);
   logic [EXP_W-1:0] exp_dec;

   assign exp_dec    = biased_exp - {{(EXP_W-1){1'b0}}, 1'b1};
   assign dec_parity = exp_dec[0];
   assign seed_exp   = EXP_BASE - {1'b0, exp_dec[EXP_W-1:1]};
endmodule

// File: rtl/rsqrt_seed_lut.sv
`timescale 1ns/1ps
module rsqrt_seed_lut
   import rsqrt_seed_pkg::*;
#(
   parameter int IDX_W  = 7,
   parameter int SEED_W = 8
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [SEED_W-1:0] seed
);
   generate
      if (IDX_W == SEED_IDX_W && SEED_W == SEED_VAL_W) begin : g_fixed_table
         assign seed = seed_lookup(idx);
      end else begin : g_bad_shape
         $error("rsqrt_seed_lut: only a 7-bit index and 8-bit entries are supported");
         assign seed = '0;
      end
   endgenerate
endmodule

// File: rtl/rsqrt_seed.sv
`timescale 1ns/1ps
module rsqrt_seed
   import rsqrt_seed_pkg::*;
#(
   parameter int               EXP_W          = 8,
   parameter int               FRAC_W         = 23,
   parameter int               IDX_FRAC_BITS  = 6,
   parameter int               SEED_W         = 8,
   parameter logic [EXP_W-1:0] SEED_EXP_BASE  = 8'hBD,
   parameter bit               STICKY_INVALID = 1'b1,
   localparam int              WORD_W         = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_operand,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_seed,
   output logic              out_invalid,
   output logic              out_summary
);
   localparam int IDX_W  = IDX_FRAC_BITS + 1;
   localparam int ZPAD_W = FRAC_W - SEED_W;
   localparam logic [WORD_W-1:0] QUIET_NAN_ENC = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
   localparam logic [WORD_W-1:0] NEG_OPND_ENC  = QUIET_NAN_ENC | WORD_W'(4);

   generate
      if (FRAC_W <= SEED_W || FRAC_W < IDX_FRAC_BITS + 3 || EXP_W < 3) begin : g_bad_widths
         $error("rsqrt_seed: fraction must exceed seed width and exponent needs 3+ bits");
      end
   endgenerate

   opnd_class_e       opnd_class;
   logic              flag_invalid;
   logic [EXP_W-1:0]  seed_exp;
   logic              dec_parity;
   logic [IDX_W-1:0]  tbl_idx;
   logic [SEED_W-1:0] tbl_val;
   logic [WORD_W-1:0] seed_next;

   rsqrt_seed_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
      .opnd         (in_operand),
      .opnd_class   (opnd_class),
      .flag_invalid (flag_invalid)
   );

   rsqrt_seed_expgen #(.EXP_W(EXP_W), .EXP_BASE(SEED_EXP_BASE)) u_expgen (
      .biased_exp (in_operand[WORD_W-2 -: EXP_W]),
      .seed_exp   (seed_exp),
      .dec_parity (dec_parity)
   );

   assign tbl_idx = {dec_parity, in_operand[FRAC_W-1 -: IDX_FRAC_BITS]};

   rsqrt_seed_lut #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_lut (
      .idx  (tbl_idx),
      .seed (tbl_val)
   );

   always_comb begin
      unique case (opnd_class)
         OPC_ANY_NAN:  seed_next = QUIET_NAN_ENC;
         OPC_TINY:     seed_next = {in_operand[WORD_W-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         OPC_NEGATIVE: seed_next = NEG_OPND_ENC;
         OPC_POS_INF:  seed_next = '0;
         default:      seed_next = {in_operand[WORD_W-1], seed_exp, tbl_val, {ZPAD_W{1'b0}}};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_seed    <= '0;
         out_summary <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_seed    <= seed_next;
            out_summary <= flag_invalid;
         end
      end
   end

   generate
      if (STICKY_INVALID) begin : g_inv_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       out_invalid <= 1'b0;
            else if (in_valid && flag_invalid) out_invalid <= 1'b1;
         end
      end else begin : g_inv_per_op
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        out_invalid <= 1'b0;
            else if (in_valid) out_invalid <= flag_invalid;
         end
      end
   endgenerate
endmodule

// File: rtl/rsqrt_seed_checker.sv
`timescale 1ns/1ps
module rsqrt_seed_checker #(
   parameter bit STICKY_INVALID = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] in_operand,
   input logic        out_valid,
   input logic [31:0] out_seed,
   input logic        out_invalid,
   input logic        out_summary
);
   logic e_ones, e_zero, f_nz, c_nan, c_tiny, c_neg, c_pinf, c_norm, c_snan;
   assign e_ones = (in_operand[30:23] == 8'hFF);
   assign e_zero = (in_operand[30:23] == 8'h00);
   assign f_nz   = (in_operand[22:0] != 23'd0);
   assign c_nan  = e_ones && f_nz;
   assign c_snan = c_nan && !in_operand[22];
   assign c_tiny = e_zero;
   assign c_neg  = in_operand[31] && !c_nan && !e_zero;
   assign c_pinf = (in_operand == 32'h7F80_0000);
   assign c_norm = !in_operand[31] && !e_ones && !e_zero;

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R10
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R10
   AST_SEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_seed) && $stable(out_summary)); // R10
   AST_NAN_ENC: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && c_nan |=> out_seed == 32'h7FC0_0000); // R2
   AST_TINY_ENC: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && c_tiny |=> out_seed[30:0] == 31'h7F80_0000 && out_seed[31] == $past(in_operand[31])); // R3
   AST_NEG_ENC: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && c_neg |=> out_seed == 32'h7FC0_0004); // R4
   AST_PINF_ENC: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && c_pinf |=> out_seed == 32'h0); // R5
   AST_NORM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && c_norm |=> !out_seed[31] && out_seed[14:0] == 15'd0); // R6
   AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (c_snan || c_neg) |=> out_invalid && out_summary); // R8
   AST_SUMMARY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !(c_snan || c_neg) |=> !out_summary); // R9
   AST_SUMMARY_IMPLIES: assert property (@(posedge clk) disable iff (!rst_n)
      out_summary |-> out_invalid); // R9

   generate
      if (STICKY_INVALID) begin : g_sticky_chk
         AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            out_invalid |=> out_invalid); // R9
      end
   endgenerate
endmodule

bind rsqrt_seed rsqrt_seed_checker #(.STICKY_INVALID(STICKY_INVALID)) u_rsqrt_seed_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_operand  (in_operand),
   .out_valid   (out_valid),
   .out_seed    (out_seed),
   .out_invalid (out_invalid),
   .out_summary (out_summary)
);

// File: tb/rsqrt_seed_tb_top.sv
`timescale 1ns/1ps
module rsqrt_seed_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_operand = 32'h0;
   logic        out_valid;
   logic [31:0] out_seed;
   logic        out_invalid;
   logic        out_summary;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  run_done = 1'b0;
   logic [7:0] seen [128];

   always #2 clk = ~clk;

   rsqrt_seed dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
      .out_valid(out_valid), .out_seed(out_seed),
      .out_invalid(out_invalid), .out_summary(out_summary)
   );

   localparam logic [7:0] REF_HEAD [64] = '{
      253, 245, 239, 231, 225, 217, 211, 205, 201, 195, 189, 185, 179, 175, 169, 165,
      161, 157, 153, 149, 145, 141, 137, 133, 131, 127, 123, 121, 117, 115, 111, 109,
      103,  99,  93,  89,  83,  79,  75,  71,  67,  63,  59,  55,  53,  49,  45,  43,
       39,  37,  33,  31,  27,  25,  23,  19,  17,  15,  13,  11,   9,   7,   5,   3
   };

   function automatic logic [31:0] ref_seed(input logic [31:0] x);
      logic [7:0] e;
      logic [7:0] em1;
      logic [6:0] i;
      e = x[30:23];
      em1 = e - 8'd1;
      i = {em1[0], x[22:17]};
      if (e == 8'hFF && x[22:0] != 0) return 32'h7FC0_0000;
      if (e == 8'h00)                  return {x[31], 31'h7F80_0000};
      if (x[31])                       return 32'h7FC0_0004;
      if (e == 8'hFF)                  return 32'h0;
      return {1'b0, 8'hBD - (em1 >> 1), REF_HEAD[i >> 1] - {7'd0, i[0]}, 15'd0};
   endfunction

   function automatic bit ref_flag(input logic [31:0] x);
      bit nan_b;
      nan_b = (x[30:23] == 8'hFF) && (x[22:0] != 0);
      return (nan_b && !x[22]) || (!nan_b && x[31] && x[30:23] != 0);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] op);
      @(negedge clk);
      in_operand = op;
      in_valid   = 1'b1;
      @(negedge clk);
      in_valid   = 1'b0;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   endtask

   // Special operand, with the sticky invalid expectation threaded through
   task automatic special(input string req, input logic [31:0] op, inout bit inv_exp);
      run_op(op);
      inv_exp = inv_exp | ref_flag(op);
      check(req, out_seed, ref_seed(op));
      check({req, "/R8 invalid"}, {31'd0, out_invalid}, {31'd0, inv_exp});
      check({req, "/R9 summary"}, {31'd0, out_summary}, {31'd0, ref_flag(op)});
   endtask

   initial begin
      bit inv_exp;
      repeat (3) @(negedge clk);
      // R1: values during reset and just after release
      check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
      check("R1 seed in reset", out_seed, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 seed", out_seed, 32'd0);
      check("R1 flags", {30'd0, out_invalid, out_summary}, 32'd0);
      check("R1 valid", {31'd0, out_valid}, 32'd0);

      inv_exp = 1'b0;
      special("R2 quiet nan", 32'h7FC0_0000, inv_exp);
      special("R2 neg quiet nan", 32'hFFC1_2345, inv_exp);
      special("R3 +0", 32'h0000_0000, inv_exp);
      special("R3 -0", 32'h8000_0000, inv_exp);
      special("R3 +denormal", 32'h0000_0001, inv_exp);
      special("R3 -denormal", 32'h807F_FFFF, inv_exp);
      special("R5 +inf", 32'h7F80_0000, inv_exp);
      special("R6 R7 one", 32'h3F80_0000, inv_exp);
      check("R6 R7 one literal", out_seed, 32'h3F7E_8000);
      special("R2 R8 signalling nan", 32'h7F80_0001, inv_exp);
      special("R9 clean after invalid", 32'h4000_0000, inv_exp);
      check("R9 invalid stays set", {31'd0, out_invalid}, 32'd1);
      special("R2 R8 neg signalling nan", 32'hFFBF_FFFF, inv_exp);
      special("R4 -inf", 32'hFF80_0000, inv_exp);
      check("R4 -inf literal", out_seed, 32'h7FC0_0004);
      special("R4 -1.0", 32'hBF80_0000, inv_exp);
      special("R4 -min normal", 32'h8080_0000, inv_exp);

      // R10: idle cycles with changing operand leave outputs untouched
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         in_operand = 32'h3F00_0000 + k;
         @(negedge clk);
         check("R10 valid low when idle", {31'd0, out_valid}, 32'd0);
         check("R10 seed held", out_seed, 32'h7FC0_0004);
         check("R10 flags held", {30'd0, out_invalid, out_summary}, 32'd3);
      end

      // R1: reset clears the sticky flag
      apply_reset();
      check("R1 reset clears invalid", {31'd0, out_invalid}, 32'd0);
      check("R1 reset clears seed", out_seed, 32'd0);

      // R6 R7: every exponent against every 6-bit prefix, low bits noisy
      for (int e = 1; e <= 254; e++) begin
         for (int m = 0; m < 64; m++) begin
            logic [31:0] op;
            logic [7:0]  em1;
            op  = {1'b0, 8'(e), 6'(m), 17'((e * 977 + m * 4099) ^ 17'h15A5A)};
            em1 = 8'(e - 1);
            run_op(op);
            check("R10 valid after strobe", {31'd0, out_valid}, 32'd1);
            check("R6 exponent", {24'd0, out_seed[30:23]}, {24'd0, 8'hBD - (em1 >> 1)});
            check("R6 sign and low bits", {16'd0, out_seed[31], out_seed[14:0]}, 32'd0);
            check("R7 table value", out_seed, ref_seed(op));
            if (e <= 2) seen[{em1[0], 6'(m)}] = out_seed[22:15];
         end
      end
      check("R9 no flag on positive sweep", {30'd0, out_invalid, out_summary}, 32'd0);

      // R7: table shape rebuilt from observed outputs
      check("R7 first entry", {24'd0, seen[0]}, 32'd253);
      check("R7 last entry", {24'd0, seen[127]}, 32'd2);
      for (int i = 0; i < 127; i++) begin
         if (i % 2 == 0)
            check("R7 pair step", {24'd0, seen[i] - seen[i + 1]}, 32'd1);
         check("R7 strictly falling", {31'd0, seen[i] > seen[i + 1]}, 32'd1);
      end

      run_done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!run_done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=running expected=done");
         finish_run();
      end
   end
endmodule